// File: doc/BRIEF.md
# Principal-Capsule Access Lookup Cache

This block decides whether a load or store is allowed. Each access names the principal that is executing, the capsule it targets, and the line of a small data cache that it touches. The block keeps a direct-mapped table of access rules. The table has no content-addressable search: the slot for a request is the XOR of the principal ID and the capsule ID. Each slot holds a valid flag, the full principal/capsule pair, and one permission bit each for reading and writing. A slot that is empty or holds a different pair is a miss, which the kernel handles and may answer by writing a rule through the fill port. A slot that matches but lacks the needed permission is a violation.

The check runs alongside the store; the store is not held up. Each data-cache line carries a pass bit. An accepted store clears the pass bit of its line at once. The pass bit is set again only when the lookup grants write permission. While a line's pass bit is clear, write-back of that line is refused and reads of that line stall at the request port.

Top module: `alc_top`

## Requirements
- R1: After reset every rule slot is invalid, all pass bits read 1 (bit i of `pass_bits` belongs to line i) and `res_valid` is 0.
- R2: The slot used by a lookup or a fill is `prin XOR cap`. A fill writes that slot unconditionally and replaces any rule already there.
- R3: A lookup hits only when the slot is valid and both stored IDs equal the request's IDs. Any other case reports `res_miss`, including a different pair that maps to the same slot.
- R4: A request accepted at a clock edge has its result during the following cycle. `res_valid` is then 1 and exactly one of `res_grant`, `res_miss`, `res_viol` is 1. With no accepted request, all four are 0.
- R5: A hit on a read is granted when the read permission is 1. A hit on a store is granted when the write permission is 1. A hit without the needed permission reports `res_viol`.
- R6: An accepted store clears its line's pass bit at the accepting edge. The bit returns to 1 at the next edge only if that store is granted. After a miss or a violation it stays 0.
- R7: `wb_allow` is 1 exactly when `wb_req` is 1 and the pass bit of `wb_line` is 1.
- R8: A read whose line has a clear pass bit raises `acc_stall` in the same cycle. The read is not accepted and produces no result. Stores never stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Access request present |
| acc_write | input | 1 | 1 = store, 0 = read |
| acc_prin | input | ID_W | Executing principal ID |
| acc_cap | input | ID_W | Target capsule ID |
| acc_line | input | LINE_W | Data-cache line touched |
| acc_stall | output | 1 | Read refused because its line is unchecked |
| res_valid | output | 1 | Verdict present for the previous accepted request |
| res_grant | output | 1 | Access permitted |
| res_miss | output | 1 | No matching rule; trap to kernel |
| res_viol | output | 1 | Rule found but permission lacking |
| fill_valid | input | 1 | Kernel writes a rule |
| fill_prin | input | ID_W | Principal ID of the rule |
| fill_cap | input | ID_W | Capsule ID of the rule |
| fill_rd | input | 1 | Read permission of the rule |
| fill_wr | input | 1 | Write permission of the rule |
| wb_req | input | 1 | Write-back of a line requested |
| wb_line | input | LINE_W | Line to write back |
| wb_allow | output | 1 | Write-back permitted |
| pass_bits | output | LINES | Pass bit per data-cache line |

## Verification
A wrong or stale rule slot shows as a wrong verdict one cycle after the first request whose ID pair maps to that slot. The bench therefore sweeps every principal/capsule pair, both before and after the table is loaded, so that every slot is read. A pass bit that is not cleared, or is set by mistake, is visible on `pass_bits` and `wb_allow` in the cycle after the store. A pass bit stuck clear turns up at the next read of that line as an unexpected `acc_stall`. Deliberate alias and overwrite cases expose a tag compare that checks only the slot index.

// File: rtl/alc_pkg.sv
package alc_pkg;
    typedef enum logic [1:0] {
        VERD_NONE  = 2'd0,
        VERD_GRANT = 2'd1,
        VERD_MISS  = 2'd2,
        VERD_VIOL  = 2'd3
    } verdict_e;
endpackage

// File: rtl/alc_judge.sv
module alc_judge
    import alc_pkg::*;
#(
    parameter int ID_W = 4
) (
    input  logic            ent_vld,
    input  logic [ID_W-1:0] ent_prin,
    input  logic [ID_W-1:0] ent_cap,
    input  logic            ent_rd,
    input  logic            ent_wr,
    input  logic            req_on,
    input  logic            req_wr,
    input  logic [ID_W-1:0] req_prin,
    input  logic [ID_W-1:0] req_cap,
    output verdict_e        verdict
);
    logic tag_hit;
    logic perm_ok;

    always_comb begin
        tag_hit = ent_vld && (ent_prin == req_prin) && (ent_cap == req_cap);
        perm_ok = req_wr ? ent_wr : ent_rd;
        if (!req_on)       verdict = VERD_NONE;
        else if (!tag_hit) verdict = VERD_MISS;
        else if (perm_ok)  verdict = VERD_GRANT;
        else               verdict = VERD_VIOL;
    end
endmodule

// File: rtl/alc_top.sv
module alc_top
    import alc_pkg::*;
#(
    parameter int ID_W  = 4,
    parameter int LINES = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      acc_valid,
    input  logic                      acc_write,
    input  logic [ID_W-1:0]           acc_prin,
    input  logic [ID_W-1:0]           acc_cap,
    input  logic [$clog2(LINES)-1:0]  acc_line,
    output logic                      acc_stall,
    output logic                      res_valid,
    output logic                      res_grant,
    output logic                      res_miss,
    output logic                      res_viol,
    input  logic                      fill_valid,
    input  logic [ID_W-1:0]           fill_prin,
    input  logic [ID_W-1:0]           fill_cap,
    input  logic                      fill_rd,
    input  logic                      fill_wr,
    input  logic                      wb_req,
    input  logic [$clog2(LINES)-1:0]  wb_line,
    output logic                      wb_allow,
    output logic [LINES-1:0]          pass_bits
);
    localparam int ENTRIES = 1 << ID_W;
    localparam int LINE_W  = $clog2(LINES);

    typedef struct packed {
        logic [ENTRIES-1:0]           vld;
        logic [ENTRIES-1:0]           prm_rd;
        logic [ENTRIES-1:0]           prm_wr;
        logic [ENTRIES-1:0][ID_W-1:0] tag_p;
        logic [ENTRIES-1:0][ID_W-1:0] tag_c;
        logic [LINES-1:0]             pass;
        logic                         pend;
        logic                         pend_wr;
        logic [ID_W-1:0]              pend_p;
        logic [ID_W-1:0]              pend_c;
        logic [LINE_W-1:0]            pend_line;
    } state_t;

    state_t s_q, s_d;

    logic [ID_W-1:0] look_idx;
    logic [ID_W-1:0] fill_idx;
    logic            accept;
    verdict_e        verdict;

    assign look_idx = s_q.pend_p ^ s_q.pend_c;
    assign fill_idx = fill_prin ^ fill_cap;

    alc_judge #(.ID_W(ID_W)) u_judge (
        .ent_vld  (s_q.vld[look_idx]),
        .ent_prin (s_q.tag_p[look_idx]),
        .ent_cap  (s_q.tag_c[look_idx]),
        .ent_rd   (s_q.prm_rd[look_idx]),
        .ent_wr   (s_q.prm_wr[look_idx]),
        .req_on   (s_q.pend),
        .req_wr   (s_q.pend_wr),
        .req_prin (s_q.pend_p),
        .req_cap  (s_q.pend_c),
        .verdict  (verdict)
    );

    assign acc_stall = acc_valid && !acc_write && !s_q.pass[acc_line];
    assign accept    = acc_valid && !acc_stall;

    assign res_valid = s_q.pend;
    assign res_grant = (verdict == VERD_GRANT);
    assign res_miss  = (verdict == VERD_MISS);
    assign res_viol  = (verdict == VERD_VIOL);
    assign wb_allow  = wb_req && s_q.pass[wb_line];
    assign pass_bits = s_q.pass;

    always_comb begin
        s_d = s_q;
        // a granted store re-arms its line
        if (s_q.pend && s_q.pend_wr && verdict == VERD_GRANT)
            s_d.pass[s_q.pend_line] = 1'b1;
        // a newly accepted store clears its line; this overrides the re-arm
        if (accept && acc_write)
            s_d.pass[acc_line] = 1'b0;
        s_d.pend      = accept;
        s_d.pend_wr   = acc_write;
        s_d.pend_p    = acc_prin;
        s_d.pend_c    = acc_cap;
        s_d.pend_line = acc_line;
        if (fill_valid) begin
            s_d.vld[fill_idx]    = 1'b1;
            s_d.tag_p[fill_idx]  = fill_prin;
            s_d.tag_c[fill_idx]  = fill_cap;
            s_d.prm_rd[fill_idx] = fill_rd;
            s_d.prm_wr[fill_idx] = fill_wr;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q      <= '0;
            s_q.pass <= '1;
        end else begin
            s_q <= s_d;
        end
    end
endmodule

// File: rtl/alc_chk.sv
module alc_chk #(
    parameter int ID_W  = 4,
    parameter int LINES = 4
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     acc_valid,
    input logic                     acc_write,
    input logic [$clog2(LINES)-1:0] acc_line,
    input logic                     acc_stall,
    input logic                     res_valid,
    input logic                     res_grant,
    input logic                     res_miss,
    input logic                     res_viol,
    input logic                     wb_req,
    input logic [$clog2(LINES)-1:0] wb_line,
    input logic                     wb_allow,
    input logic [LINES-1:0]         pass_bits
);
    AST_ONE_VERDICT: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> $countones({res_grant, res_miss, res_viol}) == 1); // R4
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |-> !(res_grant || res_miss || res_viol)); // R4
    AST_RES_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> $past(acc_valid && !acc_stall)); // R4
    AST_STORE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_write) |=> !pass_bits[$past(acc_line)]); // R6
    AST_STALL_READ_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        acc_stall |-> (acc_valid && !acc_write)); // R8
    AST_WB_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        wb_allow |-> (wb_req && pass_bits[wb_line])); // R7

    for (genvar g = 0; g < LINES; g++) begin : g_line
        AST_PASS_RISE_ON_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(pass_bits[g]) |-> $past(res_valid && res_grant)); // R6
    end
endmodule

bind alc_top alc_chk #(.ID_W(ID_W), .LINES(LINES)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc_valid (acc_valid),
    .acc_write (acc_write),
    .acc_line  (acc_line),
    .acc_stall (acc_stall),
    .res_valid (res_valid),
    .res_grant (res_grant),
    .res_miss  (res_miss),
    .res_viol  (res_viol),
    .wb_req    (wb_req),
    .wb_line   (wb_line),
    .wb_allow  (wb_allow),
    .pass_bits (pass_bits)
);

// File: tb/sim_alc_top.sv
`timescale 1ns/1ps
module sim_alc_top;
    localparam int ID_W  = 4;
    localparam int LINES = 4;
    localparam int ENT   = 1 << ID_W;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic acc_valid = 1'b0, acc_write = 1'b0;
    logic [ID_W-1:0] acc_prin = '0, acc_cap = '0;
    logic [1:0] acc_line = '0;
    logic acc_stall, res_valid, res_grant, res_miss, res_viol;
    logic fill_valid = 1'b0;
    logic [ID_W-1:0] fill_prin = '0, fill_cap = '0;
    logic fill_rd = 1'b0, fill_wr = 1'b0;
    logic wb_req = 1'b0;
    logic [1:0] wb_line = '0;
    logic wb_allow;
    logic [LINES-1:0] pass_bits;

    int checks = 0;
    int failures = 0;

    bit m_vld [ENT];
    int m_p [ENT];
    int m_c [ENT];
    bit m_rd [ENT];
    bit m_wr [ENT];
    bit m_pass [LINES];

    always #2.5 clk = ~clk;

    alc_top #(.ID_W(ID_W), .LINES(LINES)) u0 (
        .clk(clk), .rst_n(rst_n),
        .acc_valid(acc_valid), .acc_write(acc_write), .acc_prin(acc_prin),
        .acc_cap(acc_cap), .acc_line(acc_line), .acc_stall(acc_stall),
        .res_valid(res_valid), .res_grant(res_grant), .res_miss(res_miss),
        .res_viol(res_viol), .fill_valid(fill_valid), .fill_prin(fill_prin),
        .fill_cap(fill_cap), .fill_rd(fill_rd), .fill_wr(fill_wr),
        .wb_req(wb_req), .wb_line(wb_line), .wb_allow(wb_allow),
        .pass_bits(pass_bits)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_fill(input int p, input int c, input bit rd, input bit wr);
        @(negedge clk);
        fill_valid = 1'b1; fill_prin = p[ID_W-1:0]; fill_cap = c[ID_W-1:0];
        fill_rd = rd; fill_wr = wr;
        @(posedge clk);
        @(negedge clk);
        fill_valid = 1'b0;
        m_vld[p ^ c] = 1'b1; m_p[p ^ c] = p; m_c[p ^ c] = c;
        m_rd[p ^ c] = rd; m_wr[p ^ c] = wr;
    endtask

    // verdict code: 4 = grant, 2 = miss, 1 = violation
    task automatic do_access(input bit w, input int p, input int c, input int ln);
        int idx;
        bit hit, perm, exp_stall;
        int exp_code, act_code;
        idx = p ^ c;
        hit = m_vld[idx] && m_p[idx] == p && m_c[idx] == c;
        perm = w ? m_wr[idx] : m_rd[idx];
        exp_code = !hit ? 2 : (perm ? 4 : 1);
        exp_stall = !w && !m_pass[ln];
        @(negedge clk);
        acc_valid = 1'b1; acc_write = w; acc_prin = p[ID_W-1:0];
        acc_cap = c[ID_W-1:0]; acc_line = ln[1:0];
        #1;
        chk(acc_stall == exp_stall, "R8 stall", acc_stall, exp_stall);
        @(posedge clk);
        @(negedge clk);
        acc_valid = 1'b0;
        if (exp_stall) begin
            chk(res_valid == 1'b0, "R8 stalled read gives no result", res_valid, 0);
            return;
        end
        act_code = {res_grant, res_miss, res_viol};
        chk(res_valid == 1'b1, "R4 result valid", res_valid, 1);
        if (w) chk(act_code == exp_code, "R3 R5 store verdict", act_code, exp_code);
        else   chk(act_code == exp_code, "R3 R5 read verdict", act_code, exp_code);
        if (w) begin
            wb_req = 1'b1; wb_line = ln[1:0];
            #1;
            chk(pass_bits[ln] == 1'b0, "R6 pass cleared while pending", pass_bits[ln], 0);
            chk(wb_allow == 1'b0, "R7 write-back blocked", wb_allow, 0);
            wb_req = 1'b0;
            @(posedge clk);
            @(negedge clk);
            m_pass[ln] = (exp_code == 4);
            chk(pass_bits[ln] == m_pass[ln], "R6 pass after verdict", pass_bits[ln], m_pass[ln]);
            wb_req = 1'b1;
            #1;
            chk(wb_allow == m_pass[ln], "R7 write-back after verdict", wb_allow, m_pass[ln]);
            wb_req = 1'b0;
        end else begin
            @(posedge clk);
            @(negedge clk);
            chk(res_valid == 1'b0, "R4 single result", res_valid, 0);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        chk(1'b0, "watchdog", 0, 1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        for (int i = 0; i < ENT; i++) m_vld[i] = 1'b0;
        for (int i = 0; i < LINES; i++) m_pass[i] = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        chk(pass_bits == 4'hf, "R1 pass bits at reset", pass_bits, 15);
        chk(res_valid == 1'b0, "R1 no result at reset", res_valid, 0);
        for (int l = 0; l < LINES; l++) begin
            wb_req = 1'b1; wb_line = l[1:0];
            #1;
            chk(wb_allow == 1'b1, "R7 write-back after reset", wb_allow, 1);
        end
        wb_req = 1'b0;
        // empty table: every pair misses (R1 R3)
        for (int p = 0; p < ENT; p++)
            for (int c = 0; c < ENT; c++)
                do_access(1'b0, p, c, (p + c) % LINES);
        // load rules, some colliding on the same slot (R2)
        for (int p = 0; p < ENT; p++)
            do_fill(p, (p * 5 + 3) % ENT, p[0], p[1]);
        for (int p = 0; p < ENT; p++)
            for (int c = 0; c < ENT; c++)
                do_access(1'b0, p, c, (p + c) % LINES);
        for (int p = 0; p < ENT; p++)
            for (int c = 0; c < ENT; c++)
                do_access(1'b1, p, c, (p + c) % LINES);
        for (int p = 0; p < ENT; p++)
            for (int c = 0; c < ENT; c++)
                do_access(1'b0, p, c, (p + c) % LINES);
        // alias and overwrite on slot 3 (R2 R3)
        do_fill(1, 2, 1'b1, 1'b1);
        do_access(1'b1, 1, 2, 0);
        do_access(1'b0, 0, 3, 0);
        do_access(1'b0, 1, 2, 0);
        do_fill(2, 1, 1'b1, 1'b0);
        do_access(1'b0, 1, 2, 0);
        do_access(1'b0, 2, 1, 0);
        do_access(1'b1, 2, 1, 0);
        do_access(1'b0, 2, 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule